// File: doc/BRIEF.md
# Graphics Function Memory Window Register and Decoder

This block holds the 64-bit memory base register of a graphics function and decodes incoming memory requests against the 16 MB window that the register claims. Software programs the base through a configuration write port with two dword selects, low and high. The low dword reads back fixed attribute bits: memory space, 64-bit type and prefetchable. How many of the lowest base bits software may set depends on a tile-count input. A function-level reset clears only those tile-dependent bits.

Each accepted request is sorted into one of three regions of the window. Register space is the first 2 MB. The reserved hole is 2 MB up to 8 MB. The translation-table alias is 8 MB up to 16 MB. A request into the hole is flagged as unsupported and does not count as a hit. A write into the table alias produces a one-cycle invalidate pulse. The pulse carries the offset of the written entry within the table alias, so that cached translations can be dropped.

Top module: `gfx_bar_decoder`

## Requirements
- R1: After `rst`, all stored base bits are 0, every request output is 0, and the low dword reads 0x0000000C.
- R2: Low dword bits 23:4 always read 0, bit 3 reads 1, bits 2:1 read 2'b10 and bit 0 reads 0. Writes to these bits are ignored.
- R3: Low dword bits 31:26 store base address bits 31:26. High dword bits 6:0 store base address bits 38:32, and high dword bits 31:7 read 0.
- R4: `tile_mode` 0 (one tile) makes low dword bits 25:24 writable. `tile_mode` 1 (two tiles) makes bit 25 writable, and bit 24 reads 0 and does not decode. `tile_mode` 2 or 3 (four tiles) makes both bits read 0 and not decode.
- R5: A pulse on `flr` clears base bits 25:24 and leaves every other base bit unchanged.
- R6: A request hits only when `mem_space_en` is 1, `req_addr[63:39]` is 0 and `req_addr[38:24]` equals the effective base. Otherwise every request output stays 0.
- R7: A hitting request with offset `req_addr[23:0]` below 0x200000 raises `hit_regs`.
- R8: A matching request with offset from 0x200000 to 0x7FFFFF raises `unsup_req` and neither hit output.
- R9: A matching request with offset 0x800000 or above raises `hit_table`, for reads and for writes.
- R10: A write that raises `hit_table` also raises `inv_valid` for one cycle, with `inv_offset` equal to `req_addr[22:0]`. A read to the table region leaves `inv_valid` at 0.
- R11: Request outputs are registered and describe the request sampled at the previous clock edge. `cfg_rd_data` shows the dword selected by `cfg_rd_sel` at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flr | input | 1 | Function-level reset pulse |
| tile_mode | input | 2 | 0 one tile, 1 two tiles, 2/3 four tiles |
| mem_space_en | input | 1 | Memory decoding enable |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 1 | 0 low dword, 1 high dword |
| cfg_wr_data | input | 32 | Configuration write data |
| cfg_rd_sel | input | 1 | 0 low dword, 1 high dword |
| cfg_rd_data | output | 32 | Registered read data |
| req_valid | input | 1 | Memory request present |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 64 | Request address |
| hit_regs | output | 1 | Request hit register space |
| hit_table | output | 1 | Request hit the table alias |
| unsup_req | output | 1 | Request fell into the reserved hole |
| inv_valid | output | 1 | Invalidate pulse for a table write |
| inv_offset | output | 23 | Offset of the written entry in the table alias |

## Verification
The assertions assume that `rst` is held for at least one edge before any check. They also assume that `tile_mode` is a static strap: a mask is judged against the mode from the previous cycle. The stimulus changes `tile_mode` only between transactions and lets at least one idle cycle pass afterwards. Request addresses are mostly built from the bench's own copy of the effective base, so the three regions and the mismatch case all occur often.

// File: rtl/gbd_pkg.sv
package gbd_pkg;
  typedef enum logic [1:0] {
    RGN_REGS  = 2'd0,
    RGN_RSVD  = 2'd1,
    RGN_TABLE = 2'd2
  } rgn_e;

  // writable mask for base bits 25:24 given the tile strap
  function automatic logic [1:0] tile_wmask(input logic [1:0] mode);
    case (mode)
      2'd0:    tile_wmask = 2'b11;
      2'd1:    tile_wmask = 2'b10;
      default: tile_wmask = 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/gbd_base_reg.sv
module gbd_base_reg #(
  parameter int ADDR_W = 39
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 flr,
  input  logic [1:0]           tile_mode,
  input  logic                 wr_en,
  input  logic                 wr_sel,
  input  logic [31:0]          wr_data,
  input  logic                 rd_sel,
  output logic [31:0]          rd_data,
  output logic [ADDR_W-25:0]   base_eff
);
  import gbd_pkg::*;
  localparam int BASE_W = ADDR_W - 24;
  localparam int HI_W   = ADDR_W - 32;

  logic [BASE_W-1:0] base_q;
  logic [1:0]        wmask;
  logic [1:0]        tile_eff;
  logic [31:0]       lo_word, hi_word;

  assign wmask    = tile_wmask(tile_mode);
  assign tile_eff = base_q[1:0] & wmask;
  assign base_eff = {base_q[BASE_W-1:2], tile_eff};

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
    end else begin
      if (wr_en && !wr_sel) begin
        base_q[7:2] <= wr_data[31:26];
        base_q[1:0] <= (base_q[1:0] & ~wmask) | (wr_data[25:24] & wmask);
      end
      if (wr_en && wr_sel)
        base_q[BASE_W-1:8] <= wr_data[HI_W-1:0];
      if (flr)
        base_q[1:0] <= 2'b00;
    end
  end

  assign lo_word = {base_q[7:2], tile_eff, 20'h0, 1'b1, 2'b10, 1'b0};
  assign hi_word = {{(32-HI_W){1'b0}}, base_q[BASE_W-1:8]};

  always_ff @(posedge clk) begin
    if (rst) rd_data <= 32'h0000_000C;
    else     rd_data <= rd_sel ? hi_word : lo_word;
  end
endmodule

// File: rtl/gbd_region_dec.sv
module gbd_region_dec #(
  parameter int WIN_LOG2   = 24,
  parameter int REGS_LOG2  = 21,
  parameter int TABLE_LOG2 = 23
) (
  input  logic [WIN_LOG2-1:0] offset,
  output gbd_pkg::rgn_e       rgn
);
  import gbd_pkg::*;
  localparam logic [WIN_LOG2-1:0] REGS_END  = WIN_LOG2'(1) << REGS_LOG2;
  localparam logic [WIN_LOG2-1:0] TABLE_BEG = WIN_LOG2'(1) << TABLE_LOG2;

  always_comb begin
    if (offset < REGS_END)        rgn = RGN_REGS;
    else if (offset >= TABLE_BEG) rgn = RGN_TABLE;
    else                          rgn = RGN_RSVD;
  end
endmodule

// File: rtl/gfx_bar_decoder.sv
module gfx_bar_decoder #(
  parameter int ADDR_W     = 39,
  parameter int REGS_LOG2  = 21,
  parameter int TABLE_LOG2 = 23
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  flr,
  input  logic [1:0]            tile_mode,
  input  logic                  mem_space_en,
  input  logic                  cfg_wr_en,
  input  logic                  cfg_wr_sel,
  input  logic [31:0]           cfg_wr_data,
  input  logic                  cfg_rd_sel,
  output logic [31:0]           cfg_rd_data,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [63:0]           req_addr,
  output logic                  hit_regs,
  output logic                  hit_table,
  output logic                  unsup_req,
  output logic                  inv_valid,
  output logic [TABLE_LOG2-1:0] inv_offset
);
  import gbd_pkg::*;
  localparam int WIN_LOG2 = 24;
  localparam int BASE_W   = ADDR_W - WIN_LOG2;

  logic [BASE_W-1:0] base_eff;
  rgn_e              rgn;
  logic              match;

  gbd_base_reg #(.ADDR_W(ADDR_W)) u_reg (
    .clk(clk), .rst(rst), .flr(flr), .tile_mode(tile_mode),
    .wr_en(cfg_wr_en), .wr_sel(cfg_wr_sel), .wr_data(cfg_wr_data),
    .rd_sel(cfg_rd_sel), .rd_data(cfg_rd_data), .base_eff(base_eff)
  );

  gbd_region_dec #(.WIN_LOG2(WIN_LOG2), .REGS_LOG2(REGS_LOG2),
                   .TABLE_LOG2(TABLE_LOG2)) u_dec (
    .offset(req_addr[WIN_LOG2-1:0]), .rgn(rgn)
  );

  assign match = req_valid && mem_space_en
              && (req_addr[63:ADDR_W] == '0)
              && (req_addr[ADDR_W-1:WIN_LOG2] == base_eff);

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_regs   <= 1'b0;
      hit_table  <= 1'b0;
      unsup_req  <= 1'b0;
      inv_valid  <= 1'b0;
      inv_offset <= '0;
    end else begin
      hit_regs  <= match && (rgn == RGN_REGS);
      hit_table <= match && (rgn == RGN_TABLE);
      unsup_req <= match && (rgn == RGN_RSVD);
      inv_valid <= match && (rgn == RGN_TABLE) && req_write;
      if (match && (rgn == RGN_TABLE) && req_write)
        inv_offset <= req_addr[TABLE_LOG2-1:0];
    end
  end
endmodule

// File: rtl/gfx_bar_decoder_chk.sv
module gfx_bar_decoder_chk (
  input logic        clk,
  input logic        rst,
  input logic [1:0]  tile_mode,
  input logic        mem_space_en,
  input logic        cfg_rd_sel,
  input logic [31:0] cfg_rd_data,
  input logic        req_valid,
  input logic        req_write,
  input logic        hit_regs,
  input logic        hit_table,
  input logic        unsup_req,
  input logic        inv_valid
);
  a_r2_fixed_bits: assert property (@(posedge clk) disable iff (rst)
    $past(!cfg_rd_sel) |-> (cfg_rd_data[23:0] == 24'h00000C));

  a_r4_four_tiles: assert property (@(posedge clk) disable iff (rst)
    ($past(!cfg_rd_sel) && $past(tile_mode[1])) |-> (cfg_rd_data[25:24] == 2'b00));

  a_r4_two_tiles: assert property (@(posedge clk) disable iff (rst)
    ($past(!cfg_rd_sel) && $past(tile_mode == 2'd1)) |-> !cfg_rd_data[24]);

  a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(!mem_space_en || !req_valid) |-> !(hit_regs || hit_table || unsup_req || inv_valid));

  a_r8_one_region: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hit_regs, hit_table, unsup_req}));

  a_r10_inv_is_table_write: assert property (@(posedge clk) disable iff (rst)
    inv_valid |-> (hit_table && $past(req_write)));

  a_r10_table_write_inv: assert property (@(posedge clk) disable iff (rst)
    (hit_table && $past(req_write)) |-> inv_valid);

  a_r10_read_no_inv: assert property (@(posedge clk) disable iff (rst)
    $past(!req_write) |-> !inv_valid);
endmodule

bind gfx_bar_decoder gfx_bar_decoder_chk u_chk (
  .clk(clk), .rst(rst), .tile_mode(tile_mode), .mem_space_en(mem_space_en),
  .cfg_rd_sel(cfg_rd_sel), .cfg_rd_data(cfg_rd_data), .req_valid(req_valid),
  .req_write(req_write), .hit_regs(hit_regs), .hit_table(hit_table),
  .unsup_req(unsup_req), .inv_valid(inv_valid)
);

// File: tb/gfx_bar_decoder_tb.sv
module gfx_bar_decoder_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flr = 1'b0;
  logic [1:0]  tile_mode = 2'd0;
  logic        mem_space_en = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic        cfg_wr_sel = 1'b0;
  logic [31:0] cfg_wr_data = '0;
  logic        cfg_rd_sel = 1'b0;
  logic [31:0] cfg_rd_data;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [63:0] req_addr = '0;
  logic        hit_regs, hit_table, unsup_req, inv_valid;
  logic [22:0] inv_offset;

  int total = 0;
  int bad = 0;

  // bench model of the stored base
  logic [6:0] m_hi = '0;
  logic [5:0] m_lo = '0;
  logic [1:0] m_t  = '0;

  always #10 clk = ~clk;

  gfx_bar_decoder u_dut (
    .clk(clk), .rst(rst), .flr(flr), .tile_mode(tile_mode),
    .mem_space_en(mem_space_en), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
    .cfg_wr_data(cfg_wr_data), .cfg_rd_sel(cfg_rd_sel), .cfg_rd_data(cfg_rd_data),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .hit_regs(hit_regs), .hit_table(hit_table), .unsup_req(unsup_req),
    .inv_valid(inv_valid), .inv_offset(inv_offset)
  );

  function automatic logic [1:0] wm(input logic [1:0] mode);
    return (mode == 2'd0) ? 2'b11 : (mode == 2'd1) ? 2'b10 : 2'b00;
  endfunction

  function automatic logic [14:0] eff_base();
    return {m_hi, m_lo, m_t & wm(tile_mode)};
  endfunction

  function automatic logic [31:0] exp_lo();
    return {m_lo, m_t & wm(tile_mode), 20'h0, 4'hC};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = d;
    if (!sel) begin
      m_lo = d[31:26];
      m_t  = (m_t & ~wm(tile_mode)) | (d[25:24] & wm(tile_mode));
    end else begin
      m_hi = d[6:0];
    end
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic cfg_read(input logic sel, input string req);
    @(negedge clk);
    cfg_rd_sel = sel;
    @(negedge clk);
    chk(req, 64'(cfg_rd_data), sel ? 64'({25'h0, m_hi}) : 64'(exp_lo()));
  endtask

  task automatic do_req(input logic [63:0] a, input logic wr, input string req);
    logic m, rg, tb, rs;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a;
    m  = mem_space_en && (a[63:39] == 25'h0) && (a[38:24] == eff_base());
    rg = m && (a[23:0] < 24'h200000);
    tb = m && a[23];
    rs = m && !rg && !tb;
    @(negedge clk);
    req_valid = 1'b0;
    chk({req, " hit_regs R7 R11"}, 64'(hit_regs), 64'(rg));
    chk({req, " hit_table R9"}, 64'(hit_table), 64'(tb));
    chk({req, " unsup_req R8"}, 64'(unsup_req), 64'(rs));
    chk({req, " inv_valid R10"}, 64'(inv_valid), 64'(tb && wr));
    if (tb && wr) chk({req, " inv_offset R10"}, 64'(inv_offset), 64'(a[22:0]));
  endtask

  function automatic logic [63:0] at(input logic [23:0] off);
    return {25'h0, eff_base(), off};
  endfunction

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rd_data", 64'(cfg_rd_data), 64'h0000000C);
    chk("R1 outputs", 64'({hit_regs, hit_table, unsup_req, inv_valid}), 64'h0);
    rst = 1'b0;
    cfg_read(1'b1, "R1 high dword");
    cfg_read(1'b0, "R1 low dword");

    // R2 attempts to write fixed bits
    cfg_write(1'b0, 32'h00FF_FFFF);
    cfg_read(1'b0, "R2 fixed bits");
    // R3 upper bits
    cfg_write(1'b0, 32'hA800_0000);
    cfg_write(1'b1, 32'hFFFF_FF55);
    cfg_read(1'b1, "R3 high dword");
    cfg_read(1'b0, "R3 low dword");

    // R6 disabled decode
    mem_space_en = 1'b0;
    do_req(at(24'h000100), 1'b0, "R6 disabled");
    mem_space_en = 1'b1;
    do_req(at(24'h000100), 1'b0, "R7 regs");
    do_req(at(24'h1FFFFF), 1'b1, "R7 regs top");
    do_req(at(24'h200000), 1'b0, "R8 hole low");
    do_req(at(24'h7FFFFF), 1'b1, "R8 hole top");
    do_req(at(24'h800000), 1'b1, "R9 table low");
    do_req(at(24'hFFFFF8), 1'b1, "R10 table top");
    do_req(at(24'h812340), 1'b0, "R10 table read");
    do_req(at(24'h000000) | 64'h0000_0080_0000_0000, 1'b0, "R6 above width");
    do_req(at(24'h000000) ^ 64'h0000_0000_0400_0000, 1'b0, "R6 base mismatch");

    // R4 tile modes
    cfg_write(1'b0, 32'h0300_0000);
    cfg_read(1'b0, "R4 one tile");
    do_req(at(24'h900000), 1'b1, "R4 one tile decode");
    tile_mode = 2'd1; @(negedge clk);
    cfg_read(1'b0, "R4 two tiles masked");
    do_req({25'h0, m_hi, m_lo, 2'b11, 24'h000010}, 1'b0, "R4 two tiles stale bit");
    cfg_write(1'b0, 32'h0100_0000);
    cfg_read(1'b0, "R4 two tiles write");
    tile_mode = 2'd2; @(negedge clk);
    cfg_write(1'b0, 32'h0300_0000);
    cfg_read(1'b0, "R4 four tiles");
    do_req(at(24'h000010), 1'b0, "R4 four tiles decode");
    tile_mode = 2'd0; @(negedge clk);

    // R5 FLR
    cfg_write(1'b0, 32'hFF00_0000);
    @(negedge clk); flr = 1'b1; m_t = 2'b00;
    @(negedge clk); flr = 1'b0;
    cfg_read(1'b0, "R5 flr low");
    cfg_read(1'b1, "R5 flr high kept");

    // random mix
    for (int i = 0; i < 400; i++) begin
      int r = $urandom_range(0, 9);
      if (r == 0) cfg_write(1'b0, $urandom());
      else if (r == 1) cfg_write(1'b1, $urandom());
      else if (r == 2) begin
        tile_mode = 2'($urandom_range(0, 3));
        @(negedge clk);
        cfg_read(1'($urandom_range(0, 1)), "R4 R3 random read");
      end else if (r == 3) begin
        mem_space_en = ($urandom_range(0, 3) != 0);
        @(negedge clk);
      end else begin
        logic [63:0] a = at(24'($urandom()));
        if ($urandom_range(0, 4) == 0) a = a ^ (64'h1 << $urandom_range(24, 63));
        do_req(a, 1'($urandom_range(0, 1)), "R6 random");
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule